// File: doc/BRIEF.md
# Prioritised Interrupt Vector Generator

This block arbitrates the interrupt requests of two serial channels. Each channel has a receive source and a transmit source, which gives four sources in all. A source requests service when its interrupt-enable flag and its done/ready flag are both set. Any active request raises one shared interrupt request line.

When the upstream acknowledge arrives, the block freezes the highest-priority pending source. It then presents that source's vector with a valid strobe and holds both until the acknowledge is withdrawn. Each channel's base vector comes from configuration inputs. The receive source uses the base itself and the transmit source uses the next slot up.

If no source is pending when the acknowledge arrives, the block forwards the acknowledge to the next device in the daisy chain. This keeps the chain continuous.

Top module: `irq_vec_gen`

## Requirements
- R1: A source requests only while both its flags are 1: receive done with receive enable, or transmit ready with transmit enable. Either flag alone produces no request.
- R2: `irq_o` is 1 exactly when at least one source requests. It falls in the same cycle that the last requesting source's flag clears.
- R3: The fixed priority is channel 0 receive, then channel 1 receive, then channel 0 transmit, then channel 1 transmit. Both receivers rank above both transmitters.
- R4: A receive vector equals its channel's base. A transmit vector equals the base plus 4. Bases are 9-bit values such as 48 (octal 60), 128 (octal 200) and 192 to 248 (octal 300 to 370 in steps of 8).
- R5: The winner is chosen at the clock edge where `iack_i` is first seen high. `vec_o` then holds that winner while the acknowledge stays high, even if requests change.
- R6: `vec_vld_o` rises one clock after `iack_i` is first sampled high with a request pending. It falls one clock after `iack_i` is sampled low.
- R7: An acknowledge that arrives with no source pending is passed on. `iack_o` goes high one clock later and stays high until one clock after `iack_i` falls. Requests that arrive meanwhile create no vector.
- R8: `vec_vld_o` and `iack_o` are never high together. `vec_o` reads 0 whenever `vec_vld_o` is 0.
- R9: After a synchronous active-low reset, `vec_vld_o`, `iack_o` and `vec_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_done_i | input | NCH | Receive done flag per channel |
| rx_ien_i | input | NCH | Receive interrupt enable per channel |
| tx_rdy_i | input | NCH | Transmit ready flag per channel |
| tx_ien_i | input | NCH | Transmit interrupt enable per channel |
| base_vec_i | input | NCH*VW | Per-channel base vectors, channel 0 in the low bits |
| irq_o | output | 1 | Shared interrupt request |
| iack_i | input | 1 | Acknowledge from upstream |
| iack_o | output | 1 | Acknowledge passed downstream |
| vec_o | output | VW | Vector of the granted source |
| vec_vld_o | output | 1 | Vector valid strobe |

## Verification
Each source is raised with only one of its two flags and then with both. This separates the enable gating from the request line. Every source is then acknowledged alone under two base settings: console/printer bases and high bases. This shows that the receive and transmit slots land on the right channel. Mixed request patterns, such as all four sources, receiver against transmitter, and the two transmitters, show the priority order. Further tests raise a higher-priority request in the middle of a grant, and acknowledge with nothing pending. These separate the latched winner from a live one, and the pass-through path from the vector path.

// File: rtl/ivg_pkg.sv
// Shared definitions for the interrupt vector generator.
package ivg_pkg;
    // Acknowledge handling phases.
    typedef enum logic [1:0] {
        ACK_IDLE  = 2'd0,
        ACK_SERVE = 2'd1,
        ACK_PASS  = 2'd2
    } ack_state_t;
endpackage

// File: rtl/ivg_src_req.sv
// Source request gating. Each channel has a receive and a transmit source.
// The output vector lists the receive sources of all channels first and
// then the transmit sources, each in channel order. Its bit order is the
// priority order. Assumes flag inputs are synchronous to clk.
module ivg_src_req #(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0]   rx_done,
    input  logic [NCH-1:0]   rx_ien,
    input  logic [NCH-1:0]   tx_rdy,
    input  logic [NCH-1:0]   tx_ien,
    output logic [2*NCH-1:0] src_req
);
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        // Receive source: done flag gated by its enable.
        assign src_req[c]       = rx_done[c] & rx_ien[c];
        // Transmit source: ready flag gated by its enable.
        assign src_req[NCH + c] = tx_rdy[c] & tx_ien[c];
    end
endmodule

// File: rtl/ivg_prio_arb.sv
// Fixed-priority encoder. The lowest index wins. Reports whether any
// request is present and the index of the winner (0 when none).
module ivg_prio_arb #(
    parameter int NSRC  = 4,
    parameter int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]  req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the lowest priority up so the highest-priority hit is kept.
    always_comb begin
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    // Any request present.
    assign any = |req;
endmodule

// File: rtl/ivg_vec_calc.sv
// Vector formation. Source index i < NCH is channel i receive and returns
// that channel's base. Index NCH + c is channel c transmit and returns the
// base plus TX_OFS. Bases arrive packed, channel 0 in the low bits.
module ivg_vec_calc #(
    parameter int NCH    = 2,
    parameter int VW     = 9,
    parameter int TX_OFS = 4,
    parameter int IDX_W  = $clog2(2 * NCH)
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [NCH*VW-1:0] base_flat,
    output logic [VW-1:0]     vec
);
    logic [VW-1:0] base_arr [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_base
        // Unpack one channel's base.
        assign base_arr[c] = base_flat[c*VW +: VW];
    end

    // Select the base for the source and add the transmit slot offset.
    always_comb begin
        vec = '0;
        for (int c = 0; c < NCH; c++) begin
            if (idx == IDX_W'(c))       vec = base_arr[c];
            if (idx == IDX_W'(c + NCH)) vec = base_arr[c] + VW'(TX_OFS);
        end
    end
endmodule

// File: rtl/ivg_ack_fsm.sv
// Acknowledge handler. In idle, a high acknowledge is taken as a new
// acknowledge. With a request pending, the current vector is latched and
// presented as valid. With none pending, the acknowledge is forwarded.
// Either state is left only when the acknowledge is sampled low.
module ivg_ack_fsm
    import ivg_pkg::*;
#(
    parameter int VW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iack_i,
    input  logic          any_req,
    input  logic [VW-1:0] vec_in,
    output logic [VW-1:0] vec_o,
    output logic          vec_vld_o,
    output logic          iack_o
);
    ack_state_t    state_q, state_d;
    logic [VW-1:0] vec_q;

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACK_IDLE:  if (iack_i) state_d = any_req ? ACK_SERVE : ACK_PASS;
            ACK_SERVE: if (!iack_i) state_d = ACK_IDLE;
            ACK_PASS:  if (!iack_i) state_d = ACK_IDLE;
            default:   state_d = ACK_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACK_IDLE;
        else        state_q <= state_d;
    end

    // Latch the winning vector on the cycle the acknowledge is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     vec_q <= '0;
        else if (state_q == ACK_IDLE && iack_i && any_req) vec_q <= vec_in;
    end

    // Output decode.
    assign vec_vld_o = (state_q == ACK_SERVE);
    assign iack_o    = (state_q == ACK_PASS);
    assign vec_o     = vec_vld_o ? vec_q : '0;
endmodule

// File: rtl/irq_vec_gen.sv
// Prioritised interrupt vector generator, top level. Gates the per-channel
// sources, ranks them with a fixed priority, forms the vector from the
// per-channel bases and answers the acknowledge. Assumes the acknowledge
// is held high until the vector or the forwarded acknowledge is consumed.
module irq_vec_gen #(
    parameter int NCH    = 2,
    parameter int VW     = 9,
    parameter int TX_OFS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    rx_done_i,
    input  logic [NCH-1:0]    rx_ien_i,
    input  logic [NCH-1:0]    tx_rdy_i,
    input  logic [NCH-1:0]    tx_ien_i,
    input  logic [NCH*VW-1:0] base_vec_i,
    output logic              irq_o,
    input  logic              iack_i,
    output logic              iack_o,
    output logic [VW-1:0]     vec_o,
    output logic              vec_vld_o
);
    localparam int NSRC  = 2 * NCH;
    localparam int IDX_W = $clog2(NSRC);

    logic [NSRC-1:0]  src_req;
    logic             any_req;
    logic [IDX_W-1:0] win_idx;
    logic [VW-1:0]    win_vec;

    ivg_src_req #(.NCH(NCH)) u_req (
        .rx_done (rx_done_i),
        .rx_ien  (rx_ien_i),
        .tx_rdy  (tx_rdy_i),
        .tx_ien  (tx_ien_i),
        .src_req (src_req)
    );

    ivg_prio_arb #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
        .req (src_req),
        .any (any_req),
        .idx (win_idx)
    );

    ivg_vec_calc #(.NCH(NCH), .VW(VW), .TX_OFS(TX_OFS), .IDX_W(IDX_W)) u_vec (
        .idx       (win_idx),
        .base_flat (base_vec_i),
        .vec       (win_vec)
    );

    ivg_ack_fsm #(.VW(VW)) u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .iack_i    (iack_i),
        .any_req   (any_req),
        .vec_in    (win_vec),
        .vec_o     (vec_o),
        .vec_vld_o (vec_vld_o),
        .iack_o    (iack_o)
    );

    // Shared request line follows any gated source.
    assign irq_o = any_req;
endmodule

// File: rtl/ivg_checker.sv
// Protocol checks for irq_vec_gen, bound to every instance of the top.
module ivg_checker #(
    parameter int NCH = 2,
    parameter int VW  = 9
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] rx_done_i,
    input logic [NCH-1:0] rx_ien_i,
    input logic [NCH-1:0] tx_rdy_i,
    input logic [NCH-1:0] tx_ien_i,
    input logic           irq_o,
    input logic           iack_i,
    input logic           iack_o,
    input logic [VW-1:0]  vec_o,
    input logic           vec_vld_o
);
    logic pend;
    assign pend = |((rx_done_i & rx_ien_i) | (tx_rdy_i & tx_ien_i));

    // R2: request line tracks the gated sources.
    a_r2_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == pend);

    // R5: vector unchanged across consecutive valid cycles.
    a_r5_vec_held: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_vld_o && $past(vec_vld_o)) |-> $stable(vec_o));

    // R6: valid only follows an acknowledge seen with a request pending.
    a_r6_vld_from_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_vld_o) |-> ($past(iack_i) && $past(irq_o)));

    // R6: releasing the acknowledge clears both responses next cycle.
    a_r6_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !iack_i |=> (!vec_vld_o && !iack_o));

    // R7: forwarding starts only when nothing was pending.
    a_r7_pass_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iack_o) |-> ($past(iack_i) && !$past(irq_o)));

    // R8: vector and forwarded acknowledge are exclusive.
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_vld_o && iack_o));

    // R8: vector reads zero when not valid.
    a_r8_vec_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_vld_o |-> (vec_o == '0));
endmodule

bind irq_vec_gen ivg_checker #(.NCH(NCH), .VW(VW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_done_i (rx_done_i),
    .rx_ien_i  (rx_ien_i),
    .tx_rdy_i  (tx_rdy_i),
    .tx_ien_i  (tx_ien_i),
    .irq_o     (irq_o),
    .iack_i    (iack_i),
    .iack_o    (iack_o),
    .vec_o     (vec_o),
    .vec_vld_o (vec_vld_o)
);

// File: tb/irq_vec_gen_tb_top.sv
// Directed bench for irq_vec_gen.
module irq_vec_gen_tb_top;
    localparam int NCH = 2;
    localparam int VW  = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    rx_done_i = '0, rx_ien_i = '0, tx_rdy_i = '0, tx_ien_i = '0;
    logic [NCH*VW-1:0] base_vec_i = '0;
    logic              irq_o, iack_i = 1'b0, iack_o, vec_vld_o;
    logic [VW-1:0]     vec_o;

    int checks = 0;
    int errors = 0;
    int base0 = 48;
    int base1 = 128;

    irq_vec_gen #(.NCH(NCH), .VW(VW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rx_done_i(rx_done_i), .rx_ien_i(rx_ien_i),
        .tx_rdy_i(tx_rdy_i), .tx_ien_i(tx_ien_i),
        .base_vec_i(base_vec_i), .irq_o(irq_o),
        .iack_i(iack_i), .iack_o(iack_o),
        .vec_o(vec_o), .vec_vld_o(vec_vld_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Source numbering: 0 rx ch0, 1 rx ch1, 2 tx ch0, 3 tx ch1.
    function automatic int exp_vec(input int src);
        case (src)
            0: return base0;
            1: return base1;
            2: return base0 + 4;
            default: return base1 + 4;
        endcase
    endfunction

    task automatic set_src(input logic [3:0] done, input logic [3:0] en);
        rx_done_i = done[1:0]; tx_rdy_i = done[3:2];
        rx_ien_i  = en[1:0];   tx_ien_i = en[3:2];
    endtask

    task automatic set_bases(input int b0, input int b1);
        base0 = b0; base1 = b1;
        base_vec_i = {VW'(b1), VW'(b0)};
    endtask

    // One acknowledge cycle; exp_src < 0 means a pass-through is expected.
    task automatic run_ack(input int exp_src, input string req);
        @(negedge clk); iack_i = 1'b1;
        @(negedge clk);
        if (exp_src < 0) begin
            chk("R7", "iack_o on pass", int'(iack_o), 1);
            chk("R7", "vld on pass", int'(vec_vld_o), 0);
        end else begin
            chk("R6", "vld after ack", int'(vec_vld_o), 1);
            chk(req, "vector", int'(vec_o), exp_vec(exp_src));
            chk("R8", "iack_o during serve", int'(iack_o), 0);
        end
        @(negedge clk);
        if (exp_src >= 0) chk("R5", "vector held", int'(vec_o), exp_vec(exp_src));
        iack_i = 1'b0;
        @(negedge clk);
        chk("R6", "vld after release", int'(vec_vld_o), 0);
        chk("R7", "iack_o after release", int'(iack_o), 0);
        chk("R8", "vec zero idle", int'(vec_o), 0);
    endtask

    task automatic t_reset();
        chk("R9", "reset vld", int'(vec_vld_o), 0);
        chk("R9", "reset iack_o", int'(iack_o), 0);
        chk("R9", "reset vec", int'(vec_o), 0);
        chk("R2", "reset irq", int'(irq_o), 0);
    endtask

    task automatic t_gating();
        for (int s = 0; s < 4; s++) begin
            @(negedge clk); set_src(4'(1 << s), 4'h0); #1;
            chk("R1", "flag only", int'(irq_o), 0);
            set_src(4'h0, 4'(1 << s)); #1;
            chk("R1", "enable only", int'(irq_o), 0);
            set_src(4'(1 << s), 4'(1 << s)); #1;
            chk("R1", "both flags", int'(irq_o), 1);
        end
        set_src(4'h0, 4'h0);
    endtask

    task automatic t_single(input int b0, input int b1);
        set_bases(b0, b1);
        for (int s = 0; s < 4; s++) begin
            @(negedge clk); set_src(4'(1 << s), 4'hF);
            run_ack(s, "R4");
        end
        set_src(4'h0, 4'h0);
    endtask

    task automatic t_priority();
        set_bases(48, 128);
        @(negedge clk); set_src(4'hF, 4'hF); run_ack(0, "R3");
        @(negedge clk); set_src(4'b0110, 4'hF); run_ack(1, "R3");
        @(negedge clk); set_src(4'b1100, 4'hF); run_ack(2, "R3");
        @(negedge clk); set_src(4'b1110, 4'hF); run_ack(1, "R3");
        @(negedge clk); set_src(4'b1111, 4'b1100); run_ack(2, "R3");
        set_src(4'h0, 4'h0);
    endtask

    task automatic t_latch();
        set_bases(200, 248);
        @(negedge clk); set_src(4'b1000, 4'hF);
        iack_i = 1'b1;
        @(negedge clk);
        chk("R5", "grant tx1", int'(vec_o), exp_vec(3));
        set_src(4'b1001, 4'hF);
        @(negedge clk);
        chk("R5", "held despite rx0", int'(vec_o), exp_vec(3));
        chk("R5", "still valid", int'(vec_vld_o), 1);
        iack_i = 1'b0;
        @(negedge clk);
        chk("R6", "drop", int'(vec_vld_o), 0);
        run_ack(0, "R3");
        set_src(4'h0, 4'h0);
    endtask

    task automatic t_pass();
        @(negedge clk); set_src(4'h0, 4'hF);
        iack_i = 1'b1;
        @(negedge clk);
        chk("R7", "forwarded", int'(iack_o), 1);
        set_src(4'b0001, 4'hF);
        @(negedge clk);
        chk("R7", "late req no vld", int'(vec_vld_o), 0);
        chk("R7", "still forwarded", int'(iack_o), 1);
        chk("R8", "vec zero on pass", int'(vec_o), 0);
        iack_i = 1'b0;
        @(negedge clk);
        chk("R7", "forward ends", int'(iack_o), 0);
        set_src(4'h0, 4'h0);
        run_ack(-1, "R7");
    endtask

    task automatic t_clear();
        @(negedge clk); set_src(4'b0101, 4'hF); #1;
        chk("R2", "irq two sources", int'(irq_o), 1);
        set_src(4'b0100, 4'hF); #1;
        chk("R2", "irq one left", int'(irq_o), 1);
        set_src(4'b0000, 4'hF); #1;
        chk("R2", "irq cleared", int'(irq_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        set_bases(48, 128);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_gating();
        t_single(48, 128);
        t_single(248, 192);
        t_priority();
        t_latch();
        t_pass();
        t_clear();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule